// File: doc/BRIEF.md
# Capture Storage Qualification Controller

This block sits between an acquisition front end and a sample memory and decides, one sample at a time, which samples are written. Each sample arrives on a parallel bus with a valid strobe. The block selects samples using one of four selection modes, which are described below. The trigger sequencer can also send per-sample keep and drop actions, which override the selected mode for that one sample.

For each stored sample the block produces a write strobe, a circular write address and a timestamp. The timestamp counts clock cycles from arming without pause, so any gap in the stored data shows up as a jump in timestamp value.

An optional neighbourhood mode widens each selected sample into a run of `PRE` samples before it and `PRE` samples after it. Overlapping runs merge, and no sample is written twice. A trigger input limits how many more words may be written before the block stops and raises a done flag, so the words stored before the trigger are kept. A pulse on the arm input starts a new acquisition.

Top module: `capture_store_ctrl`

## Requirements
- R1: After reset, and on the cycle after an arm pulse, `wr_en_o` and `done_o` are low. The first write after arming uses address 0.
- R2: With `mode_i`=0 (all), every valid sample is written, in arrival order.
- R3: With `mode_i`=1 (qualified), a valid sample is written only when `qual_i` is high in the same cycle.
- R4: With `mode_i`=2 (window), a start action opens a window and a stop action closes it. A start action applies to the sample it arrives with. A stop action excludes the sample it arrives with. Actions count only when `samp_valid_i` is high.
- R5: With `mode_i`=3 (transitional), a sample is written when it differs from the previous valid sample. The first valid sample after arming is always written.
- R6: `keep_act_i` forces the current sample to be written in any mode. `drop_act_i` forces it to be skipped. If both are high, drop takes precedence.
- R7: With `block_en_i` high, every sample within `PRE` valid samples of a selected sample is written, once only, in order. A sample is written when the valid sample `PRE` positions later arrives.
- R8: `wr_ts_o` equals the number of clock cycles between the first clock edge after arming and the cycle in which the sample was presented. Idle cycles are included in the count.
- R9: The write address increases by one with each write and wraps from `DEPTH-1` to 0.
- R10: After `trig_i`, at most `POST_DEPTH` further words are written, counting any write in the trigger's own cycle. `done_o` then goes high and no further writes occur until the next arm.
- R11: A sample written in single mode appears on `wr_en_o`/`wr_data_o` exactly one cycle after it is presented.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| arm_i | input | 1 | Starts a new acquisition: clears all state and enables storage |
| mode_i | input | 2 | Selection mode: 0 all, 1 qualified, 2 window, 3 transitional |
| block_en_i | input | 1 | Enables neighbourhood storage of ±PRE samples |
| samp_i | input | SAMP_W | Sample data |
| samp_valid_i | input | 1 | Sample strobe |
| qual_i | input | 1 | Store condition used in qualified mode |
| start_act_i | input | 1 | Window-open action |
| stop_act_i | input | 1 | Window-close action |
| keep_act_i | input | 1 | Forces the current sample to be stored |
| drop_act_i | input | 1 | Forces the current sample to be skipped |
| trig_i | input | 1 | Trigger; starts the post-trigger word count |
| wr_en_o | output | 1 | Memory write strobe |
| wr_addr_o | output | $clog2(DEPTH) | Memory write address |
| wr_data_o | output | SAMP_W | Stored sample |
| wr_ts_o | output | TS_W | Timestamp of the stored sample |
| done_o | output | 1 | Post-trigger budget used up |

## Verification
In single mode, a write appears on the output registers on the first clock edge after its sample is presented. In neighbourhood mode, a sample's write appears after the edge that takes in the valid sample `PRE` positions later. Timestamps are counted from the edge that follows arming.

The bench drives inputs on falling edges and reads outputs on falling edges. A monitor records every write on a falling edge. After each run, the recorded list is compared with a list computed arithmetically from the requirements, covering data, timestamp, address, count and order. The one-cycle latency is also checked directly on the first sample of a run. The done flag is checked after the post-trigger budget is used up.

// File: rtl/csq_pkg.sv
package csq_pkg;
  typedef enum logic [1:0] {
    MODE_ALL   = 2'd0,
    MODE_QUAL  = 2'd1,
    MODE_WIN   = 2'd2,
    MODE_TRANS = 2'd3
  } store_mode_e;
endpackage

// File: rtl/csq_qualify.sv
module csq_qualify
  import csq_pkg::*;
#(
  parameter int SAMP_W = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              arm_i,
  input  store_mode_e       mode_i,
  input  logic              valid_i,
  input  logic [SAMP_W-1:0] samp_i,
  input  logic              qual_i,
  input  logic              start_i,
  input  logic              stop_i,
  input  logic              keep_i,
  input  logic              drop_i,
  output logic              hit_o
);
  logic              win_q, have_prev_q;
  logic [SAMP_W-1:0] prev_q;
  logic              win_now, base_hit;

  always_comb begin
    win_now = start_i ? 1'b1 : (stop_i ? 1'b0 : win_q);
    unique case (mode_i)
      MODE_ALL:   base_hit = 1'b1;
      MODE_QUAL:  base_hit = qual_i;
      MODE_WIN:   base_hit = win_now;
      MODE_TRANS: base_hit = !have_prev_q || (samp_i != prev_q);
      default:    base_hit = 1'b0;
    endcase
    hit_o = valid_i && !drop_i && (keep_i || base_hit);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      win_q       <= 1'b0;
      have_prev_q <= 1'b0;
      prev_q      <= '0;
    end else if (arm_i) begin
      win_q       <= 1'b0;
      have_prev_q <= 1'b0;
      prev_q      <= '0;
    end else if (valid_i) begin
      win_q       <= win_now;
      have_prev_q <= 1'b1;
      prev_q      <= samp_i;
    end
  end

  // R5: reference sample after arming is always taken
  a_r5_first_stored: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i == MODE_TRANS && valid_i && !have_prev_q && !drop_i) |-> hit_o);
endmodule

// File: rtl/csq_block.sv
module csq_block #(
  parameter int SAMP_W = 16,
  parameter int TS_W   = 50,
  parameter int PRE    = 31
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              arm_i,
  input  logic              block_en_i,
  input  logic              valid_i,
  input  logic              hit_i,
  input  logic [SAMP_W-1:0] samp_i,
  input  logic [TS_W-1:0]   ts_i,
  output logic              out_en_o,
  output logic [SAMP_W-1:0] out_samp_o,
  output logic [TS_W-1:0]   out_ts_o
);
  localparam int SPAN   = 2 * PRE + 1;
  localparam int CNT_W  = $clog2(SPAN + 1);
  localparam int FILL_W = $clog2(PRE + 1);

  logic [SAMP_W-1:0] dl_samp [PRE];
  logic [TS_W-1:0]   dl_ts   [PRE];
  logic [CNT_W-1:0]  cnt_q, cnt_nxt;
  logic [FILL_W-1:0] fill_q;
  logic              primed;

  always_comb begin
    if (hit_i)            cnt_nxt = CNT_W'(SPAN);
    else if (cnt_q != '0) cnt_nxt = cnt_q - 1'b1;
    else                  cnt_nxt = '0;
    primed = (fill_q == FILL_W'(PRE));
    if (block_en_i) begin
      out_en_o   = valid_i && primed && (cnt_nxt != '0);
      out_samp_o = dl_samp[PRE-1];
      out_ts_o   = dl_ts[PRE-1];
    end else begin
      out_en_o   = hit_i;
      out_samp_o = samp_i;
      out_ts_o   = ts_i;
    end
  end

  // delay line holds the PRE most recent valid samples, oldest at the tail
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int k = 0; k < PRE; k++) begin
        dl_samp[k] <= '0;
        dl_ts[k]   <= '0;
      end
      cnt_q  <= '0;
      fill_q <= '0;
    end else if (arm_i) begin
      cnt_q  <= '0;
      fill_q <= '0;
    end else if (valid_i) begin
      dl_samp[0] <= samp_i;
      dl_ts[0]   <= ts_i;
      for (int k = 1; k < PRE; k++) begin
        dl_samp[k] <= dl_samp[k-1];
        dl_ts[k]   <= dl_ts[k-1];
      end
      cnt_q <= cnt_nxt;
      if (!primed) fill_q <= fill_q + 1'b1;
    end
  end

  // R7: the window count never lengthens without a fresh selected sample
  a_r7_cnt_decay: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && !hit_i && !arm_i) |=> (cnt_q <= $past(cnt_q)));
endmodule

// File: rtl/csq_tstamp.sv
module csq_tstamp #(
  parameter int TS_W = 50
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            arm_i,
  output logic [TS_W-1:0] ts_o
);
  logic [TS_W-1:0] ts_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    ts_q <= '0;
    else if (arm_i) ts_q <= '0;
    else            ts_q <= ts_q + 1'b1;
  end

  assign ts_o = ts_q;

  a_r8_ts_free_run: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !arm_i |=> (ts_q == $past(ts_q) + TS_W'(1)));
endmodule

// File: rtl/csq_addr.sv
module csq_addr #(
  parameter int DEPTH      = 64,
  parameter int POST_DEPTH = 48
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     arm_i,
  input  logic                     fire_i,
  input  logic                     trig_i,
  output logic [$clog2(DEPTH)-1:0] addr_o,
  output logic                     done_o
);
  localparam int AW = $clog2(DEPTH);
  localparam int PW = $clog2(POST_DEPTH + 1);

  logic [AW-1:0] addr_q;
  logic [PW-1:0] post_q;
  logic          trig_q, done_q, trig_now;

  assign trig_now = trig_i || trig_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      addr_q <= '0;
      post_q <= '0;
      trig_q <= 1'b0;
      done_q <= 1'b0;
    end else if (arm_i) begin
      addr_q <= '0;
      post_q <= '0;
      trig_q <= 1'b0;
      done_q <= 1'b0;
    end else begin
      if (trig_i) trig_q <= 1'b1;
      if (fire_i) begin
        addr_q <= (addr_q == AW'(DEPTH - 1)) ? '0 : addr_q + 1'b1;
        if (trig_now) begin
          post_q <= post_q + 1'b1;
          if (post_q == PW'(POST_DEPTH - 1)) done_q <= 1'b1;
        end
      end
    end
  end

  assign addr_o = addr_q;
  assign done_o = done_q;

  a_r9_addr_wrap: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fire_i && !arm_i) |=> (addr_q == (($past(addr_q) == AW'(DEPTH - 1)) ? '0 : $past(addr_q) + 1'b1)));
endmodule

// File: rtl/capture_store_ctrl.sv
module capture_store_ctrl
  import csq_pkg::*;
#(
  parameter int SAMP_W     = 16,
  parameter int TS_W       = 50,
  parameter int PRE        = 31,
  parameter int DEPTH      = 64,
  parameter int POST_DEPTH = 48
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     arm_i,
  input  logic [1:0]               mode_i,
  input  logic                     block_en_i,
  input  logic [SAMP_W-1:0]        samp_i,
  input  logic                     samp_valid_i,
  input  logic                     qual_i,
  input  logic                     start_act_i,
  input  logic                     stop_act_i,
  input  logic                     keep_act_i,
  input  logic                     drop_act_i,
  input  logic                     trig_i,
  output logic                     wr_en_o,
  output logic [$clog2(DEPTH)-1:0] wr_addr_o,
  output logic [SAMP_W-1:0]        wr_data_o,
  output logic [TS_W-1:0]          wr_ts_o,
  output logic                     done_o
);
  localparam int AW = $clog2(DEPTH);

  logic              armed_q, valid_g, hit, blk_en, fire, trig_g;
  logic [TS_W-1:0]   ts;
  logic [SAMP_W-1:0] blk_samp;
  logic [TS_W-1:0]   blk_ts;
  logic [AW-1:0]     addr;
  logic              done;

  assign valid_g = samp_valid_i && armed_q && !arm_i;
  assign fire    = blk_en && armed_q && !done && !arm_i;
  assign trig_g  = trig_i && armed_q && !done && !arm_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    armed_q <= 1'b0;
    else if (arm_i) armed_q <= 1'b1;
  end

  csq_tstamp #(.TS_W(TS_W)) ts_i (
    .clk_i(clk_i), .rst_ni(rst_ni), .arm_i(arm_i), .ts_o(ts)
  );

  csq_qualify #(.SAMP_W(SAMP_W)) qual_i0 (
    .clk_i(clk_i), .rst_ni(rst_ni), .arm_i(arm_i),
    .mode_i(store_mode_e'(mode_i)), .valid_i(valid_g), .samp_i(samp_i),
    .qual_i(qual_i), .start_i(start_act_i), .stop_i(stop_act_i),
    .keep_i(keep_act_i), .drop_i(drop_act_i), .hit_o(hit)
  );

  csq_block #(.SAMP_W(SAMP_W), .TS_W(TS_W), .PRE(PRE)) blk_i (
    .clk_i(clk_i), .rst_ni(rst_ni), .arm_i(arm_i), .block_en_i(block_en_i),
    .valid_i(valid_g), .hit_i(hit), .samp_i(samp_i), .ts_i(ts),
    .out_en_o(blk_en), .out_samp_o(blk_samp), .out_ts_o(blk_ts)
  );

  csq_addr #(.DEPTH(DEPTH), .POST_DEPTH(POST_DEPTH)) addr_i (
    .clk_i(clk_i), .rst_ni(rst_ni), .arm_i(arm_i), .fire_i(fire),
    .trig_i(trig_g), .addr_o(addr), .done_o(done)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_en_o   <= 1'b0;
      wr_addr_o <= '0;
      wr_data_o <= '0;
      wr_ts_o   <= '0;
    end else begin
      wr_en_o <= fire;
      if (fire) begin
        wr_addr_o <= addr;
        wr_data_o <= blk_samp;
        wr_ts_o   <= blk_ts;
      end
    end
  end

  assign done_o = done;

  a_r10_halt_after_done: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && !arm_i) |=> !wr_en_o);
  a_r11_write_follows_sample: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_o |-> $past(samp_valid_i && armed_q && !arm_i));
endmodule

// File: tb/capture_store_ctrl_tb_top.sv
module capture_store_ctrl_tb_top;
  localparam int SW = 8, TW = 50, PRE = 4, DEPTH = 32, POST = 12;
  localparam int AW = $clog2(DEPTH);

  logic clk = 1'b0, rst_n = 1'b0;
  logic arm = 0, blk = 0, valid = 0, qual = 0, st = 0, sp = 0, kp = 0, dr = 0, trig = 0;
  logic [1:0] mode = 0;
  logic [SW-1:0] samp = '0;
  logic wr_en, done;
  logic [AW-1:0] wr_addr;
  logic [SW-1:0] wr_data;
  logic [TW-1:0] wr_ts;

  always #4 clk = ~clk;

  capture_store_ctrl #(.SAMP_W(SW), .TS_W(TW), .PRE(PRE), .DEPTH(DEPTH), .POST_DEPTH(POST)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .arm_i(arm), .mode_i(mode), .block_en_i(blk),
    .samp_i(samp), .samp_valid_i(valid), .qual_i(qual), .start_act_i(st),
    .stop_act_i(sp), .keep_act_i(kp), .drop_act_i(dr), .trig_i(trig),
    .wr_en_o(wr_en), .wr_addr_o(wr_addr), .wr_data_o(wr_data), .wr_ts_o(wr_ts),
    .done_o(done)
  );

  int checks = 0, errors = 0;

  task automatic chk(input string req, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // stimulus record and model state
  logic [SW-1:0] s_dat [128];
  longint        s_ts  [128];
  bit            s_hit [128];
  bit            s_trg [128];
  int            ns;
  longint        cyc;
  bit            m_win, m_have;
  logic [SW-1:0] m_prev;

  // monitor
  logic [SW-1:0] w_dat [256];
  longint        w_ts  [256];
  int            w_adr [256];
  int            nw;
  always @(negedge clk)
    if (wr_en && nw < 256) begin
      w_dat[nw] = wr_data; w_ts[nw] = wr_ts; w_adr[nw] = int'(wr_addr); nw++;
    end

  task automatic do_arm(input int m, input bit b);
    @(negedge clk);
    arm = 1; mode = 2'(m); blk = b; valid = 0;
    @(negedge clk);
    arm = 0;
    chk("R1 wr_en after arm", longint'(wr_en), 0);
    chk("R1 done after arm", longint'(done), 0);
    nw = 0; ns = 0; cyc = 0; m_win = 0; m_have = 0; m_prev = '0;
  endtask

  task automatic step(input bit v, input logic [SW-1:0] d, input bit q,
                      input bit a_st, input bit a_sp, input bit a_kp, input bit a_dr, input bit a_tg);
    bit wn, base, h;
    valid = v; samp = d; qual = q; st = a_st; sp = a_sp; kp = a_kp; dr = a_dr; trig = a_tg;
    if (v) begin
      wn = a_st ? 1'b1 : (a_sp ? 1'b0 : m_win);
      case (mode)
        2'd0: base = 1;
        2'd1: base = q;
        2'd2: base = wn;
        default: base = !m_have || (d != m_prev);
      endcase
      h = !a_dr && (a_kp || base);
      s_dat[ns] = d; s_ts[ns] = cyc; s_hit[ns] = h; s_trg[ns] = a_tg; ns++;
      m_win = wn; m_prev = d; m_have = 1;
    end
    @(negedge clk);
    cyc++;
    valid = 0; qual = 0; st = 0; sp = 0; kp = 0; dr = 0; trig = 0;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) step(0, '0, 0, 0, 0, 0, 0, 0);
  endtask

  task automatic verify(input string req, input bit b);
    int  e, post, tk;
    bit  sel, halted;
    e = 0; post = 0; halted = 0; tk = 0;
    for (int i = 0; i < ns; i++) begin
      if (s_trg[i]) tk = 1;
      if (b) begin
        sel = 0;
        if (i + PRE < ns)
          for (int j = i - PRE; j <= i + PRE; j++)
            if (j >= 0 && j < ns && s_hit[j]) sel = 1;
      end else sel = s_hit[i];
      if (sel && !halted) begin
        if (e < nw) begin
          chk({req, " data"}, longint'(w_dat[e]), longint'(s_dat[i]));
          chk("R8 timestamp", w_ts[e], s_ts[i]);
          chk("R9 address", longint'(w_adr[e]), longint'(e % DEPTH));
        end
        e++;
        if (tk) begin post++; if (post == POST) halted = 1; end
      end
    end
    chk({req, " write count"}, longint'(nw), longint'(e));
  endtask

  initial begin
    for (int i = 0; i < 200000; i++) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    nw = 0;
    #20;
    chk("R1 wr_en in reset", longint'(wr_en), 0);
    chk("R1 done in reset", longint'(done), 0);
    @(negedge clk); rst_n = 1;

    // R2 store all, with idle gaps, more writes than DEPTH (R9 wrap), R11 latency
    do_arm(0, 0);
    for (int i = 0; i < 50; i++) begin
      if (i % 5 == 3) idle(1);
      else step(1, SW'(i * 7 + 3), 0, 0, 0, 0, 0, 0);
      if (i == 0) begin
        chk("R11 one-cycle latency en", longint'(wr_en), 1);
        chk("R11 one-cycle latency data", longint'(wr_data), 3);
        chk("R1 first address", longint'(wr_addr), 0);
      end
    end
    idle(2); verify("R2", 0);

    // R3 qualified
    do_arm(1, 0);
    for (int i = 0; i < 30; i++) step(1, SW'(i + 40), (i % 3 == 0), 0, 0, 0, 0, 0);
    idle(2); verify("R3", 0);

    // R4 window by start/stop actions
    do_arm(2, 0);
    for (int i = 0; i < 30; i++) begin
      if (i == 7) idle(1);
      step(1, SW'(i + 90), 0, (i == 5 || i == 20), (i == 12 || i == 25), 0, 0, 0);
    end
    idle(2); verify("R4", 0);

    // R5 transitional
    do_arm(3, 0);
    for (int i = 0; i < 30; i++) step(1, SW'(i / 3 + ((i == 10) ? 1 : 0)), 0, 0, 0, 0, 0, 0);
    idle(2); verify("R5", 0);

    // R6 override actions in qualified mode
    do_arm(1, 0);
    for (int i = 0; i < 24; i++)
      step(1, SW'(i + 7), (i % 4 == 0), 0, 0, (i % 5 == 1 || i == 12), (i == 8 || i == 12), 0);
    idle(2); verify("R6", 0);

    // R7 neighbourhood mode: clipped start, merged runs, isolated run
    do_arm(1, 1);
    for (int i = 0; i < 50; i++) begin
      if (i == 20) idle(2);
      step(1, SW'(i * 3 + 1), (i == 1 || i == 14 || i == 18 || i == 40), 0, 0, 0, 0, 0);
    end
    idle(2); verify("R7", 1);

    // R10 trigger limits post-trigger writes, addresses wrap
    do_arm(0, 0);
    for (int i = 0; i < 60; i++) step(1, SW'(i + 100), 0, 0, 0, 0, 0, (i == 30));
    idle(2); verify("R10", 0);
    chk("R10 done raised", longint'(done), 1);
    do_arm(0, 0);
    chk("R1 done cleared by arm", longint'(done), 0);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule